// File: doc/BRIEF.md
# Transposed-Form Fixed-Point FIR Filter

This block is a parameterised FIR filter in transposed form, working on signed fixed-point samples. On every enabled cycle the current input sample is multiplied by all coefficients at once. The products are folded into a chain of partial-sum registers, one register per tap. Each partial sum is requantised to the output format as it is stored. The filtered value leaves the far end of the chain. An optional run of extra output registers then pads the total delay to the configured latency.

Coefficients are fixed when the design is elaborated. They are given as 32-bit signed integers with a source fractional precision, and are rounded into the coefficient format. The input, coefficient and output formats, the tap count and the latency are all parameters. A latency below one cycle, a negative requantisation shift, or a coefficient source precision that is not finer than the coefficient format is rejected at elaboration. At least two taps are expected.

Top module: `fir_tpose`

## Requirements
- R1: A synchronous reset clears every partial-sum register and every output delay register, so `dout` reads 0 after the reset edge and after any reset applied in the middle of a run.
- R2: Coefficient k is taken from bits [32k+31:32k] of `COEFS` as a signed value with `SRC_FRAC` fractional bits. It is rounded to `C_FRAC` fractional bits by adding half an LSB and flooring, so ties go toward plus infinity, and it is wrapped to `C_W` bits.
- R3: On an enabled cycle, partial-sum register 0 loads the quantised product of the last coefficient (index TAPS-1) and the current input.
- R4: On an enabled cycle, partial-sum register i (1 to TAPS-1) loads the quantised sum of the old value of register i-1 and coefficient TAPS-1-i times the current input.
- R5: Quantisation drops the X_FRAC+C_FRAC-O_FRAC extra fractional bits by truncation toward minus infinity, and wraps the integer part into `O_W` signed bits with no saturation.
- R6: A sample accepted on enabled edge n first affects `dout` just after enabled edge n+LAT-1. With LAT=1, `dout` is the last partial-sum register itself.
- R7: While `en` is low, all partial-sum and delay registers hold, so `dout` does not change.
- R8: After reset, an impulse of amplitude A followed by zeros makes `dout` run through the quantised values of coefficient 0·A, coefficient 1·A, and so on up to coefficient TAPS-1·A, then return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable; when low, all state holds |
| din | input | X_W | Signed input sample, X_FRAC fractional bits |
| dout | output | O_W | Signed filtered output, O_FRAC fractional bits |

## Verification
On every cycle the assertions check the following:
- `dout` and the chain endpoints hold while the enable is low.
- Reset clears the output and the chain.
- A zero input makes register 0 load zero.
- A zero input makes the last register take the previous one unchanged.

The full arithmetic can only be shown by the bench's scenarios. That covers coefficient rounding and wrap, the order of accumulation with per-step truncation, output wrap and the exact latency. The bench drives impulses, a sweep over every input code and a random run with gaps in the enable. It compares each output against a direct-form model that quantises in the same order.

// File: rtl/fir_tpose.sv
module fir_tpose #(
  parameter int TAPS     = 4,
  parameter int X_W      = 8,
  parameter int X_FRAC   = 0,
  parameter int C_W      = 8,
  parameter int C_FRAC   = 6,
  parameter int SRC_FRAC = 16,
  parameter int O_W      = 10,
  parameter int O_FRAC   = 2,
  parameter int LAT      = 3,
  parameter logic [TAPS*32-1:0] COEFS = {32'sd163840, -32'sd33280, 32'sd19968, 32'sd49152}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic signed [X_W-1:0] din,
  output logic signed [O_W-1:0] dout
);
  localparam int PW = X_W + C_W;
  localparam int SH = X_FRAC + C_FRAC - O_FRAC;
  localparam int SW = ((O_W + SH > PW) ? O_W + SH : PW) + 1;
  localparam int RS = SRC_FRAC - C_FRAC;

  if (LAT < 1) begin : g_bad_lat
    $error("fir_tpose: LAT must be at least 1");
  end
  if (SH < 0) begin : g_bad_fmt
    $error("fir_tpose: output has more fractional bits than the product");
  end
  if (RS < 1) begin : g_bad_src
    $error("fir_tpose: SRC_FRAC must exceed C_FRAC");
  end

  logic signed [PW-1:0]  prod  [TAPS];
  logic signed [O_W-1:0] chain [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic signed [31:0] RAW = COEFS[k*32 +: 32];
    localparam logic signed [31:0] RND = (RAW + (32'sd1 <<< (RS - 1))) >>> RS;
    localparam logic signed [C_W-1:0] CF = RND[C_W-1:0];
    assign prod[k] = PW'(din) * PW'(CF);
  end

  function automatic logic signed [O_W-1:0] quant(input logic signed [O_W-1:0] acc,
                                                  input logic signed [PW-1:0] p);
    logic signed [SW-1:0] s;
    s = (SW'(acc) <<< SH) + SW'(p);
    s = s >>> SH;
    return s[O_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) chain[i] <= '0;
    end else if (en) begin
      chain[0] <= quant('0, prod[TAPS-1]);
      for (int i = 1; i < TAPS; i++) chain[i] <= quant(chain[i-1], prod[TAPS-1-i]);
    end
  end

  if (LAT == 1) begin : g_direct
    assign dout = chain[TAPS-1];
  end else begin : g_delay
    logic signed [O_W-1:0] dly [LAT-1];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < LAT - 1; i++) dly[i] <= '0;
      end else if (en) begin
        dly[0] <= chain[TAPS-1];
        for (int i = 1; i < LAT - 1; i++) dly[i] <= dly[i-1];
      end
    end
    assign dout = dly[LAT-2];
  end
endmodule

module fir_tpose_chk #(
  parameter int X_W = 8,
  parameter int O_W = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  en,
  input logic signed [X_W-1:0] din,
  input logic signed [O_W-1:0] dout,
  input logic signed [O_W-1:0] head,
  input logic signed [O_W-1:0] tail,
  input logic signed [O_W-1:0] prev
);
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(dout));
  // R7
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(head) && $stable(tail)));
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (dout == '0 && head == '0 && tail == '0));
  // R3
  zero_head_chk: assert property (@(posedge clk) disable iff (rst)
    (en && din == '0) |=> head == '0);
  // R4
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (en && din == '0) |=> tail == $past(prev));
endmodule

bind fir_tpose fir_tpose_chk #(.X_W(X_W), .O_W(O_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout),
  .head(chain[0]), .tail(chain[TAPS-1]), .prev(chain[TAPS-2])
);

// File: tb/fir_tpose_bench.sv
module fir_tpose_bench;
  localparam int TAPS = 4, X_W = 8, X_FRAC = 0, C_W = 8, C_FRAC = 6;
  localparam int SRC_FRAC = 16, O_W = 10, O_FRAC = 2, LAT = 3;
  localparam int SH = X_FRAC + C_FRAC - O_FRAC;
  localparam int RS = SRC_FRAC - C_FRAC;
  // coef0=0.75, coef1=19.5/64 (tie up), coef2=-32.5/64 (tie up), coef3=2.5 (wraps)
  localparam logic [TAPS*32-1:0] CW = {32'sd163840, -32'sd33280, 32'sd19968, 32'sd49152};

  logic clk = 0, rst = 1, en = 0;
  logic signed [X_W-1:0] din = '0;
  logic signed [O_W-1:0] dout;
  int total = 0, bad = 0;
  bit done = 0;
  longint cf [TAPS];
  longint hist [TAPS];
  longint line [LAT];

  always #5 clk = ~clk;

  fir_tpose #(.TAPS(TAPS), .X_W(X_W), .X_FRAC(X_FRAC), .C_W(C_W), .C_FRAC(C_FRAC),
              .SRC_FRAC(SRC_FRAC), .O_W(O_W), .O_FRAC(O_FRAC), .LAT(LAT), .COEFS(CW))
    u_fir_tpose (.clk(clk), .rst(rst), .en(en), .din(din), .dout(dout));

  function automatic longint wrap(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  function automatic longint qf(longint a, longint p);
    return wrap(((a <<< SH) + p) >>> SH, O_W);
  endfunction

  task automatic clear_model();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    for (int k = 0; k < LAT; k++) line[k] = 0;
  endtask

  task automatic model_step(longint x);
    longint acc;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    acc = qf(0, cf[TAPS-1] * hist[TAPS-1]);
    for (int k = TAPS - 2; k >= 0; k--) acc = qf(acc, cf[k] * hist[k]);
    for (int k = LAT - 1; k > 0; k--) line[k] = line[k-1];
    line[0] = acc;
  endtask

  task automatic chk(string tag, longint exp);
    total++;
    if (longint'(dout) != exp) begin
      bad++;
      $display("FAIL %s: dout=%0d expected=%0d at %0t", tag, dout, exp, $time);
    end
  endtask

  task automatic cyc(logic e, longint x, string tag);
    @(negedge clk);
    en = e;
    din = X_W'(x);
    @(posedge clk);
    if (e && !rst) model_step(x);
    #1;
    chk(tag, line[LAT-1]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    en = 1;
    din = 8'sd77;
    @(posedge clk);
    #1;
    clear_model();
    chk("R1", 0);
    @(negedge clk);
    rst = 0;
    en = 0;
  endtask

  initial begin
    for (int k = 0; k < TAPS; k++) begin
      logic signed [31:0] r;
      r = CW[k*32 +: 32];
      cf[k] = wrap((longint'(r) + (64'sd1 <<< (RS - 1))) >>> RS, C_W);
    end
    clear_model();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 0);
    do_reset();

    // impulses: R2 R8 coefficient readout, R6 latency of its first nonzero sample
    cyc(1, 64, "R2 R6 R8");
    for (int i = 0; i < TAPS + LAT; i++) cyc(1, 0, "R2 R6 R8");
    cyc(1, -128, "R2 R5 R8");
    for (int i = 0; i < TAPS + LAT; i++) cyc(1, 0, "R2 R5 R8");

    // sweep over every input code
    for (int v = -128; v < 128; v++) cyc(1, v, "R3 R4 R5");
    for (int v = 127; v >= -128; v -= 3) cyc(1, v, "R3 R4 R5");

    // random run with enable gaps
    for (int i = 0; i < 600; i++) begin
      logic e;
      e = ($urandom_range(3) != 0);
      cyc(e, longint'($signed(8'($urandom))), e ? "R6" : "R7");
    end
    for (int i = 0; i < 8; i++) cyc(0, 100, "R7");

    // reset mid-run, then state must be clean
    do_reset();
    cyc(1, 64, "R1");
    for (int i = 0; i < TAPS + LAT; i++) cyc(1, 0, "R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule